// File: doc/BRIEF.md
# Display Timing Event Clock Generator

This block turns panel sync activity into two streams of one-cycle events, a line tick and a frame tick, for a display timing unit. It holds two 16-bit down-counters: a line counter and a frame counter. Each one has its own count source, its own hardware reload trigger and its own software force-reload. All of these choices, and the two output ticks, are picked from one shared pool of eight events. The pool holds the rising and falling edges of the horizontal sync, vertical sync and tearing-effect inputs, plus the underflow of either counter.

The sync inputs are asynchronous. Each one passes through a two-flop synchronizer and then an edge detector. The two counters are cross-coupled: each counter can count, or be reloaded, on the other's underflow. Each underflow is a registered pulse, so one counter's underflow reaches the other counter one clock later, and the design has no combinational loop.

The select fields, force bits and reload values arrive on a plain configuration port that a register block outside this one drives.

Top module: `disp_evt_clkgen`

## Requirements
- R1: The line tick output select `cfg_line_out_sel` picks one event from the pool. The encoding is: 0 = line counter underflow, 1 = frame counter underflow, 2 = horizontal sync rising edge, 3 = horizontal sync falling edge, 4 = vertical sync rising edge, 5 = vertical sync falling edge, 6 = tearing-effect rising edge, 7 = tearing-effect falling edge.
- R2: The frame tick output select `cfg_frame_out_sel` uses the same eight-way encoding as R1 and drives `frame_tick`.
- R3: Line counter count source `cfg_line_cnt_en`:
  - 0 holds the line counter.
  - 1 decrements it on every clock.
  - When the counter is advanced at zero, it raises an underflow pulse one cycle long and wraps to `line_rld_val`.
  - After a load of value V, the first underflow comes V+1 clocks later, and further underflows come every V+1 clocks.
- R4: Frame counter count source `cfg_frame_cnt_sel`:
  - 0 holds the counter.
  - 1 advances it on line counter underflow.
  - Codes 2 to 7 advance it on the sync edges, in the same order as R1.
  - Underflow and wrap work as in R3, with `frame_rld_val`.
- R5: Line counter hardware reload select `cfg_line_rld_sel`: 0 = never, 1 = on frame counter underflow, codes 2 to 7 = on the sync edges in the R1 order. The reload loads `line_rld_val`.
- R6: Frame counter hardware reload select `cfg_frame_rld_sel`: 0 = never, 1 = on line counter underflow, codes 2 to 7 = on the sync edges in the R1 order. The reload loads `frame_rld_val`.
- R7: A 1 on `line_force_rld` or `frame_force_rld` loads that counter with its reload value at the next clock edge. A 0 has no effect.
- R8: Synchronous active-low reset clears both counters, both underflow pulses and the synchronizers. With all select fields at 0, neither tick is ever raised.
- R9: Each sync input gives exactly one one-cycle rising-edge pulse per rising edge, and one falling-edge pulse per falling edge. The pulse is visible after the second clock edge that follows the input change.
- R10: When a reload (forced or hardware) falls in the same cycle as an advance, the reload wins and no underflow is signalled.
- R11: A counter's underflow pulse is registered. A line underflow therefore advances the frame counter on the clock edge after the line underflow first shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| te_in | input | 1 | Panel tearing-effect signal, asynchronous |
| cfg_line_out_sel | input | 3 | Event driving `line_tick` (R1) |
| cfg_frame_out_sel | input | 3 | Event driving `frame_tick` (R2) |
| cfg_line_cnt_en | input | 1 | Line counter count source (R3) |
| cfg_frame_cnt_sel | input | 3 | Frame counter count source (R4) |
| cfg_line_rld_sel | input | 3 | Line counter hardware reload source (R5) |
| cfg_frame_rld_sel | input | 3 | Frame counter hardware reload source (R6) |
| line_force_rld | input | 1 | Force a line counter reload |
| frame_force_rld | input | 1 | Force a frame counter reload |
| line_rld_val | input | CNT_W | Line counter reload value |
| frame_rld_val | input | CNT_W | Frame counter reload value |
| line_tick | output | 1 | One-cycle line clock event |
| frame_tick | output | 1 | One-cycle frame clock event |

## Verification
The bench builds the block with its default parameters: 16-bit counters and a two-stage synchronizer. It programs reload values between 0 and 20, so counter wraps, frame underflows driven by line underflows, and underflow-triggered reloads all occur within a few dozen cycles. The zero reload value reaches the case where a counter underflows on every advance. Sync pulses are spaced so that each edge code can be told apart by the exact cycle of its tick.

// File: rtl/disp_evt_pkg.sv
// Shared definitions for the display timing event clock generator.
// Assumes an eight-entry event pool indexed by a three-bit select code.
package disp_evt_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_EVT = 1 << SEL_W;
    localparam int N_SYNC  = 3;

    typedef logic [SEL_W-1:0] evt_sel_t;

    // Position of each event in the shared pool; the select codes depend on it.
    typedef enum logic [SEL_W-1:0] {
        EV_LINE_UF  = 3'd0,
        EV_FRAME_UF = 3'd1,
        EV_HS_RISE  = 3'd2,
        EV_HS_FALL  = 3'd3,
        EV_VS_RISE  = 3'd4,
        EV_VS_FALL  = 3'd5,
        EV_TE_RISE  = 3'd6,
        EV_TE_FALL  = 3'd7
    } evt_id_e;
endpackage

// File: rtl/disp_sync_edge.sv
// Synchronizes one asynchronous level into the system clock domain and
// produces one-cycle rising and falling edge pulses.
// Assumes the input stays stable for at least one clock between changes.
module disp_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] shf_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= {shf_q[LAST-1:0], din};
    end

    assign rise = shf_q[LAST-1] & ~shf_q[LAST];
    assign fall = ~shf_q[LAST-1] & shf_q[LAST];

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)); // R9
    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R9
endmodule

// File: rtl/disp_evt_pick.sv
// Picks one event out of the shared pool by a select code.
// CODE0_NONE makes code 0 mean "no event"; code 1 is remapped to pool
// entry CODE1_IDX; other codes index the pool directly.
module disp_evt_pick
    import disp_evt_pkg::*;
#(
    parameter bit CODE0_NONE = 1'b0,
    parameter int CODE1_IDX  = 1
) (
    input  logic [NUM_EVT-1:0] pool,
    input  evt_sel_t           sel,
    output logic               evt
);
    localparam evt_sel_t IDX1 = evt_sel_t'(CODE1_IDX);

    // Decode the select code into a single event.
    always_comb begin
        if (CODE0_NONE && sel == '0) evt = 1'b0;
        else if (sel == evt_sel_t'(1)) evt = pool[IDX1];
        else evt = pool[sel];
    end
endmodule

// File: rtl/disp_evt_counter.sv
// Reloadable down-counter with a registered underflow pulse.
// Assumes advance and reload are single-cycle qualified strobes; reload
// has priority and suppresses the underflow.
module disp_evt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             reload,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uf_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             uf_q;

    // Count state: reload wins, otherwise decrement or wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            uf_q  <= 1'b0;
        end else if (reload) begin
            cnt_q <= rld_val;
            uf_q  <= 1'b0;
        end else if (adv) begin
            cnt_q <= (cnt_q == '0) ? rld_val : cnt_q - 1'b1;
            uf_q  <= (cnt_q == '0);
        end else begin
            uf_q  <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign uf_o  = uf_q;

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt_q == $past(rld_val)); // R7
    AST_RELOAD_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !uf_q); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !reload) |=> ($stable(cnt_q) && !uf_q)); // R3
    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reload && cnt_q == '0) |=> (uf_q && cnt_q == $past(rld_val))); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reload && cnt_q != '0) |=> (!uf_q && cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/disp_evt_clkgen.sv
// Display timing event clock generator: two cross-coupled down-counters
// whose count source, reload trigger and output ticks are chosen from a
// shared pool of synchronized sync edges and registered underflows.
// Assumes configuration inputs are quasi-static apart from the force bits.
module disp_evt_clkgen
    import disp_evt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             te_in,
    input  logic [2:0]       cfg_line_out_sel,
    input  logic [2:0]       cfg_frame_out_sel,
    input  logic             cfg_line_cnt_en,
    input  logic [2:0]       cfg_frame_cnt_sel,
    input  logic [2:0]       cfg_line_rld_sel,
    input  logic [2:0]       cfg_frame_rld_sel,
    input  logic             line_force_rld,
    input  logic             frame_force_rld,
    input  logic [CNT_W-1:0] line_rld_val,
    input  logic [CNT_W-1:0] frame_rld_val,
    output logic             line_tick,
    output logic             frame_tick
);
    logic [NUM_EVT-1:0] pool;
    logic [N_SYNC-1:0]  sync_in;
    logic [N_SYNC-1:0]  sy_rise, sy_fall;
    logic               line_uf, frame_uf;
    logic               frame_adv, line_hw_rld, frame_hw_rld;
    logic               line_reload, frame_reload;
    logic [CNT_W-1:0]   line_cnt, frame_cnt;

    assign sync_in = {te_in, vsync_in, hsync_in};

    // One synchronizer and edge detector per sync input; pool order is fixed.
    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        disp_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_se (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_in[g]),
            .rise (sy_rise[g]),
            .fall (sy_fall[g])
        );
        assign pool[int'(EV_HS_RISE) + 2*g] = sy_rise[g];
        assign pool[int'(EV_HS_FALL) + 2*g] = sy_fall[g];
    end

    assign pool[EV_LINE_UF]  = line_uf;
    assign pool[EV_FRAME_UF] = frame_uf;

    // Output tick selection: all eight codes index the pool directly.
    disp_evt_pick #(.CODE0_NONE(1'b0), .CODE1_IDX(int'(EV_FRAME_UF))) u_line_out (
        .pool(pool), .sel(cfg_line_out_sel), .evt(line_tick));
    disp_evt_pick #(.CODE0_NONE(1'b0), .CODE1_IDX(int'(EV_FRAME_UF))) u_frame_out (
        .pool(pool), .sel(cfg_frame_out_sel), .evt(frame_tick));

    // Frame count source: code 0 off, code 1 line underflow.
    disp_evt_pick #(.CODE0_NONE(1'b1), .CODE1_IDX(int'(EV_LINE_UF))) u_frame_cs (
        .pool(pool), .sel(cfg_frame_cnt_sel), .evt(frame_adv));

    // Hardware reload sources: code 0 none, code 1 the other counter's underflow.
    disp_evt_pick #(.CODE0_NONE(1'b1), .CODE1_IDX(int'(EV_FRAME_UF))) u_line_hr (
        .pool(pool), .sel(cfg_line_rld_sel), .evt(line_hw_rld));
    disp_evt_pick #(.CODE0_NONE(1'b1), .CODE1_IDX(int'(EV_LINE_UF))) u_frame_hr (
        .pool(pool), .sel(cfg_frame_rld_sel), .evt(frame_hw_rld));

    assign line_reload  = line_force_rld  | line_hw_rld;
    assign frame_reload = frame_force_rld | frame_hw_rld;

    disp_evt_counter #(.CNT_W(CNT_W)) u_line_cnt (
        .clk(clk), .rst_n(rst_n), .adv(cfg_line_cnt_en), .reload(line_reload),
        .rld_val(line_rld_val), .cnt_o(line_cnt), .uf_o(line_uf));

    disp_evt_counter #(.CNT_W(CNT_W)) u_frame_cnt (
        .clk(clk), .rst_n(rst_n), .adv(frame_adv), .reload(frame_reload),
        .rld_val(frame_rld_val), .cnt_o(frame_cnt), .uf_o(frame_uf));

    AST_LINE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_line_cnt_en |=> !line_uf); // R3
    AST_FRAME_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_frame_cnt_sel == 3'd0) |=> !frame_uf); // R4
    AST_XCOUPLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_frame_cnt_sel == 3'd1 && line_uf && !frame_reload && frame_cnt == '0)
        |=> frame_uf); // R11
    AST_LINE_HW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_line_rld_sel == 3'd1 && frame_uf) |=> line_cnt == $past(line_rld_val)); // R5
    AST_FRAME_HW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_frame_rld_sel == 3'd1 && line_uf) |=> (!frame_uf && frame_cnt == $past(frame_rld_val))); // R6
endmodule

// File: tb/sim_disp_evt_clkgen.sv
`timescale 1ns/1ps
module sim_disp_evt_clkgen;
    localparam int CNT_W = 16;
    localparam int WIN   = 41;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 1'b0, vs = 1'b0, te = 1'b0;
    logic [2:0] lo = '0, fo = '0, fc = '0, lr = '0, fr = '0;
    logic en = 1'b0, lf = 1'b0, ff = 1'b0;
    logic [CNT_W-1:0] rl = '0, rf = '0;
    logic line_tick, frame_tick;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    disp_evt_clkgen #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .te_in(te),
        .cfg_line_out_sel(lo), .cfg_frame_out_sel(fo), .cfg_line_cnt_en(en),
        .cfg_frame_cnt_sel(fc), .cfg_line_rld_sel(lr), .cfg_frame_rld_sel(fr),
        .line_force_rld(lf), .frame_force_rld(ff),
        .line_rld_val(rl), .frame_rld_val(rf),
        .line_tick(line_tick), .frame_tick(frame_tick));

    typedef struct packed {
        logic        en;
        logic [2:0]  lo, fo, fc, lr, fr;
        logic [15:0] rl, rf;
        logic [7:0]  xl, xf;
    } row_t;

    // Window of 41 edges after a forced reload of both counters.
    localparam row_t ROWS [6] = '{
        '{1'b1, 3'd0, 3'd1, 3'd1, 3'd0, 3'd0, 16'd3, 16'd1, 8'd10, 8'd4 },  // R3 R4 R11
        '{1'b1, 3'd0, 3'd1, 3'd1, 3'd0, 3'd0, 16'd0, 16'd0, 8'd40, 8'd39},  // R3 zero reload
        '{1'b0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 16'd3, 16'd1, 8'd0,  8'd0 },  // R3 R4 disabled
        '{1'b1, 3'd1, 3'd0, 3'd1, 3'd0, 3'd0, 16'd3, 16'd1, 8'd4,  8'd10},  // R1 R2 codes 0/1
        '{1'b1, 3'd0, 3'd1, 3'd1, 3'd0, 3'd1, 16'd3, 16'd1, 8'd10, 8'd0 },  // R6 R10
        '{1'b1, 3'd0, 3'd1, 3'd1, 3'd1, 3'd0, 16'd3, 16'd0, 8'd7,  8'd6 }   // R5
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Force both counters at edge 1, then count ticks over n edges.
    task automatic run_win(input int n, output int nl, output int nf,
                           output int fl, output int ffirst);
        nl = 0; nf = 0; fl = -1; ffirst = -1;
        lf = 1'b1; ff = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            lf = 1'b0; ff = 1'b0;
            if (line_tick)  begin nl++; if (fl < 0) fl = i; end
            if (frame_tick) begin nf++; if (ffirst < 0) ffirst = i; end
        end
    endtask

    initial begin
        #100_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int nl, nf, fl, fi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state, all selects zero
        nl = 0; nf = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
            if (line_tick) nl++;
            if (frame_tick) nf++;
        end
        chk(nl == 0, "R8 line ticks after reset", nl, 0);
        chk(nf == 0, "R8 frame ticks after reset", nf, 0);

        // Table walk
        for (int r = 0; r < 6; r++) begin
            en = ROWS[r].en; lo = ROWS[r].lo; fo = ROWS[r].fo; fc = ROWS[r].fc;
            lr = ROWS[r].lr; fr = ROWS[r].fr; rl = ROWS[r].rl; rf = ROWS[r].rf;
            run_win(WIN, nl, nf, fl, fi);
            chk(nl == int'(ROWS[r].xl), $sformatf("R3/R1 row %0d line count", r), nl, int'(ROWS[r].xl));
            chk(nf == int'(ROWS[r].xf), $sformatf("R4/R2 row %0d frame count", r), nf, int'(ROWS[r].xf));
        end

        // R11: line reload 2 gives first line underflow at edge 4, frame at edge 5
        en = 1'b1; lo = 3'd0; fo = 3'd1; fc = 3'd1; lr = 3'd0; fr = 3'd0; rl = 16'd2; rf = 16'd0;
        run_win(8, nl, nf, fl, fi);
        chk(fl == 4, "R3 first line underflow edge", fl, 4);
        chk(fi == 5, "R11 first frame underflow edge", fi, 5);

        // R7: forcing every 4 edges with reload 5 keeps the line counter from underflowing
        en = 1'b1; lo = 3'd0; fo = 3'd1; fc = 3'd0; lr = 3'd0; rl = 16'd5;
        nl = 0;
        for (int i = 0; i < 40; i++) begin
            lf = (i % 4 == 0);
            @(posedge clk); @(negedge clk);
            if (line_tick) nl++;
        end
        lf = 1'b0;
        chk(nl == 0, "R7 repeated force reload", nl, 0);

        // R1 R2 R9: each sync edge code, exact tick cycle
        en = 1'b0; fc = 3'd0; lr = 3'd0; fr = 3'd0;
        for (int c = 2; c < 8; c++) begin
            int expi, lcnt, fcnt, lidx, fidx;
            lo = 3'(c); fo = 3'(c);
            expi = 10 * ((c - 2) / 2) + ((c % 2 == 1) ? 5 : 0) + 1;
            lcnt = 0; fcnt = 0; lidx = -1; fidx = -1;
            for (int i = 0; i < 30; i++) begin
                hs = (i < 5);
                vs = (i >= 10 && i < 15);
                te = (i >= 20 && i < 25);
                @(posedge clk); @(negedge clk);
                if (line_tick)  begin lcnt++; lidx = i; end
                if (frame_tick) begin fcnt++; fidx = i; end
            end
            chk(lcnt == 1 && lidx == expi, $sformatf("R1 R9 line code %0d tick cycle", c), lidx, expi);
            chk(fcnt == 1 && fidx == expi, $sformatf("R2 R9 frame code %0d tick cycle", c), fidx, expi);
        end

        // R4: frame counter counted by HSYNC rise (code 2), reload 2, six pulses
        lo = 3'd0; fo = 3'd1; fc = 3'd2; rf = 16'd2; en = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            nf = 0;
            ff = 1'b1;
            for (int i = 0; i < 40; i++) begin
                hs = (i < 36) && ((i % 6) < 3);
                @(posedge clk); @(negedge clk);
                ff = 1'b0;
                if (frame_tick) nf++;
            end
            chk(nf == (pass == 0 ? 2 : 0), "R4 frame count by HSYNC rise / disabled", nf, pass == 0 ? 2 : 0);
            fc = 3'd0;
        end

        // R5: VSYNC rise (code 4) reloads line counter every 10 edges, reload 20
        en = 1'b1; lo = 3'd0; fo = 3'd0; rl = 16'd20;
        for (int pass = 0; pass < 2; pass++) begin
            lr = (pass == 0) ? 3'd4 : 3'd0;
            nl = 0;
            lf = 1'b1;
            for (int i = 1; i <= 81; i++) begin
                vs = ((i % 10) < 5);
                @(posedge clk); @(negedge clk);
                lf = 1'b0;
                if (line_tick) nl++;
            end
            chk(nl == (pass == 0 ? 0 : 3), "R5 VSYNC rise hardware reload", nl, pass == 0 ? 0 : 3);
        end
        vs = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule